// File: doc/BRIEF.md
# Two-Read One-Write Register File on Phase-Shared Single-Port Storage

This block is a processor register file. It has one writeback port and two operand read ports. It is built from two identical single-port storage arrays. Each array has one address, and that address is shared across the two halves of every clock cycle. The destination register number must be valid while the clock is low. The write lands on the rising edge. Each read port's source register number must be valid while the clock is high. The selected word is captured into that port's output register on the falling edge.

Every write goes to both arrays. Array 0 then serves read port A and array 1 serves read port B, so the two ports can select any two registers independently. A register written on a rising edge can be read in the high phase that follows, and the operand captured on the next falling edge is the new value. The data width and register count are parameters, with defaults of 32 bits and 16 registers. The 16x16, 16x32 and 32x32 configurations are all intended uses. The array contents are undefined until each register has been written.

Top module: `phase_regfile`

## Requirements
- R1: When `wr_en` is high at a rising edge of `clk`, `wr_data` is stored into register `wr_idx` of both storage copies.
- R2: When `wr_en` is low at a rising edge, no register changes; a later read returns the value held before that edge.
- R3: At each falling edge with `rst` low, `rd_data_a` captures the register selected by `rd_idx_a` and `rd_data_b` captures the register selected by `rd_idx_b`, each port independently.
- R4: A register written on a rising edge and selected by a read port in the following high phase yields the newly written value at the next falling edge.
- R5: When both read ports select the same register, both outputs carry the same value.
- R6: Read outputs stay unchanged from one falling edge to the next, including across the rising edge in between.
- R7: Reset is synchronous and active high. At a falling edge with `rst` high, both read outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; low phase carries the write address, high phase the read addresses |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| wr_en | input | 1 | Writeback enable, sampled at the rising edge |
| wr_idx | input | $clog2(NREGS) | Destination register number |
| wr_data | input | DW | Writeback data |
| rd_idx_a | input | $clog2(NREGS) | Source register number for port A |
| rd_idx_b | input | $clog2(NREGS) | Source register number for port B |
| rd_data_a | output | DW | Captured operand, port A |
| rd_data_b | output | DW | Captured operand, port B |

## Verification
The assertions check on every cycle that:
- an enabled write lands in both copies with identical contents;
- a disabled write leaves each copy stable;
- each falling-edge capture equals the addressed word of that port's own copy;
- reset zeroes the outputs.

Only the bench's scenarios can show that operands match the architectural register state over long random sequences. The same holds for a same-cycle write followed by a read of that register, and for both ports aimed at one register. The bench also checks outputs between the edges to confirm that they hold through the rising edge.

// File: rtl/phase_regfile.sv
module phase_regfile #(
  parameter int DW    = 32,
  parameter int NREGS = 16,
  localparam int AW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx_a,
  input  logic [AW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);

  logic [1:0][DW-1:0] port_q;
  logic [1:0][AW-1:0] port_idx;

  assign port_idx  = {rd_idx_b, rd_idx_a};
  assign rd_data_a = port_q[0];
  assign rd_data_b = port_q[1];

  // Each copy: low phase presents wr_idx (sampled at posedge),
  // high phase presents the port's read index (sampled at negedge).
  for (genvar c = 0; c < 2; c++) begin : g_copy
    logic [NREGS-1:0][DW-1:0] mem;

    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_ff @(negedge clk) begin
      if (rst) port_q[c] <= '0;
      else     port_q[c] <= mem[port_idx[c]];
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> g_copy[0].mem[$past(wr_idx)] == $past(wr_data)); // R1

  AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> g_copy[0].mem[$past(wr_idx)] == g_copy[1].mem[$past(wr_idx)]); // R1

  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(g_copy[0].mem) && $stable(g_copy[1].mem)); // R2

  AST_PORT_A_CAPTURE: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> rd_data_a == $past(g_copy[0].mem[rd_idx_a])); // R3

  AST_PORT_B_CAPTURE: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> rd_data_b == $past(g_copy[1].mem[rd_idx_b])); // R3

  AST_RESET_CLEARS: assert property (@(negedge clk)
    rst |=> rd_data_a == '0 && rd_data_b == '0); // R7

endmodule

// File: tb/phase_regfile_tb_top.sv
module phase_regfile_tb_top;
  localparam int DW = 32;
  localparam int NREGS = 16;
  localparam int AW = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_idx = '0, rd_idx_a = '0, rd_idx_b = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data_a, rd_data_b;

  always #4 clk = ~clk;

  phase_regfile #(.DW(DW), .NREGS(NREGS)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b));

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] ref_m [NREGS];
  bit valid [NREGS];
  logic [DW-1:0] exp_a, exp_b;
  bit ok_a = 0, ok_b = 0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_read(logic [AW-1:0] i);
    return ref_m[i];
  endfunction

  // Called at negedge+1; drives one cycle and checks around both edges.
  task automatic step(bit we, logic [AW-1:0] wi, logic [DW-1:0] wd,
                      logic [AW-1:0] ra, logic [AW-1:0] rb, string req);
    wr_en = we; wr_idx = wi; wr_data = wd; rd_idx_a = ra; rd_idx_b = rb;
    @(posedge clk); #1;
    if (ok_a) chk("R6 hold A", rd_data_a, exp_a);
    if (ok_b) chk("R6 hold B", rd_data_b, exp_b);
    if (we) begin ref_m[wi] = wd; valid[wi] = 1; end
    @(negedge clk); #1;
    exp_a = model_read(ra); ok_a = valid[ra];
    exp_b = model_read(rb); ok_b = valid[rb];
    if (ok_a) chk(req, rd_data_a, exp_a);
    if (ok_b) chk(req, rd_data_b, exp_b);
    if (ra == rb && ok_a) chk("R5 same reg", rd_data_a, rd_data_b);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (valid[i]) valid[i] = 0;
    repeat (2) @(negedge clk);
    #1;
    chk("R7 reset A", rd_data_a, '0);
    chk("R7 reset B", rd_data_b, '0);
    rst = 1'b0;
    // R1: fill every register, reading back the one written before
    for (int i = 0; i < NREGS; i++)
      step(1, AW'(i), 32'hA500_0000 + DW'(i) * 32'h0101, AW'(i > 0 ? i - 1 : 0),
           AW'(i > 0 ? i - 1 : 0), "R1 write fill");
    // R4: back-to-back write then read same register
    step(1, 4'd3, 32'hDEAD_BEEF, 4'd3, 4'd7, "R4 fresh write A");
    step(1, 4'd3, 32'h1234_5678, 4'd9, 4'd3, "R4 fresh write B");
    step(1, 4'd5, 32'h0F0F_0F0F, 4'd5, 4'd5, "R4 R5 both ports");
    // R2: disabled write to the register being read
    step(0, 4'd5, 32'hFFFF_FFFF, 4'd5, 4'd3, "R2 no write");
    step(0, 4'd0, 32'h0000_0000, 4'd0, 4'd5, "R2 no write");
    // R3: independent ports, distinct registers
    step(0, 4'd0, '0, 4'd1, 4'd14, "R3 independent");
    step(0, 4'd0, '0, 4'd15, 4'd0, "R3 independent");
    // random traffic
    for (int n = 0; n < 2000; n++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom);
      step(bit'($urandom_range(0, 1)), AW'($urandom), DW'($urandom), ra,
           ($urandom_range(0, 3) == 0) ? ra : AW'($urandom), "R3 random");
    end
    // R7: reset mid-run clears outputs at the falling edge
    rst = 1'b1;
    @(negedge clk); #1;
    chk("R7 midrun A", rd_data_a, '0);
    chk("R7 midrun B", rd_data_b, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule